// File: doc/BRIEF.md
# Two-wire register slave with grouped pointer stepping

This block is the serial front end of a register-mapped peripheral. It listens on a two-wire bus (SCL and SDA), answers to one of four 7-bit device addresses chosen by a 2-bit select code, and gives a register file one write port and one read port. It has no storage of its own apart from an 8-bit register pointer, which keeps its value from one transfer to the next. Both bus lines are first synchronised to the system clock. A line must then hold a new level for a set number of cycles before the block accepts it, so short spikes do not count as edges.

The first byte after a write address loads the pointer. Every further byte of that write goes to the register the pointer selects, and the pointer then moves on. A read has no byte of its own for the pointer. It starts at the stored pointer and moves on after each byte in the same way. The pointer does not count linearly. It stays inside fixed groups: some addresses swap with their partner, two addresses never move, and one block of eight addresses steps upward and wraps.

Top module: `twi_grp_slave`

## Requirements
- R1: The device address is {addr_sel[1], 1, 0, 0, addr_sel[0], 0, 0} (bit 6 down to bit 0), followed by the R/W bit (1 = read). The block acknowledges its own address for all four select codes, and it does not acknowledge any other address.
- R2: The first byte after a write address loads the pointer. If a STOP follows that byte, the transfer only stores the pointer, and a later read with no pointer byte starts from it.
- R3: Each data byte after the pointer byte gives one single-cycle wr_stb pulse. wr_addr carries the low REG_AW bits of the pointer and wr_data carries the byte. The pointer then advances.
- R4: Pointers 0x00/0x01, 0x02/0x03, 0x06/0x07 and 0x0A/0x0B each swap with their partner after each access.
- R5: Pointers 0x0E and 0x0F stay the same after each access.
- R6: Pointers 0x10 to 0x16 step up by one after each access, and 0x17 goes back to 0x10.
- R7: A read returns the byte on rd_data for rd_addr (the low REG_AW bits of the pointer), most significant bit first. Each byte loaded gives one single-cycle rd_stb pulse and advances the pointer. After the master answers with NACK, the block sends nothing more.
- R8: Acknowledge means the block holds SDA low (sda_pull_o = 1) for the whole high phase of the 9th clock.
- R9: A low rst_n, held for one or more clock edges, ends any transfer in progress, releases SDA and sets the pointer to 0x00. The block then waits for a START.
- R10: Bytes written while the pointer is 0x00 or 0x01 give no wr_stb pulse, but the pointer still swaps.
- R11: A pointer outside the known groups (such as 0x05 or 0x1C) is still acknowledged. Writes there give no wr_stb, reads there return 0x00, and the pointer does not move.
- R12: A repeated START starts a new address phase and keeps the stored pointer.
- R13: The block ignores a pulse on SCL or SDA that is shorter than FILT_HOLD (default 3) system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (the open-drain driver's enable) |
| addr_sel | input | 2 | Device address select code |
| wr_addr | output | REG_AW | Register file write address |
| wr_data | output | 8 | Register file write data |
| wr_stb | output | 1 | Write strobe, one cycle |
| rd_addr | output | REG_AW | Register file read address (the pointer) |
| rd_data | input | 8 | Register file read data for rd_addr |
| rd_stb | output | 1 | One-cycle pulse when a byte is taken for reading |

## Verification
The case that is hardest to reach from the ports is a reset that lands in the middle of a data byte. It needs a valid address and pointer byte first, then reset between two SCL edges. The bench runs a full write header, clocks half a data byte, pulls rst_n low while SCL is high, and then checks three things: SDA is released, no write strobe appears, and a read with no pointer byte returns register 0x00. A second hard case is a one-cycle spike on SCL inside a data bit. The bench drives that spike on every bit of a write and reads the values back. Random transfers over every pointer group then exercise the grouped stepping, checked against a model of the pointer.

// File: rtl/twi_grp_pkg.sv
package twi_grp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } twi_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } twi_phase_e;

  // Pointer values that belong to a register group
  function automatic logic ptr_known(input logic [7:0] p);
    return (p < 8'h04) || (p == 8'h06) || (p == 8'h07) ||
           (p == 8'h0A) || (p == 8'h0B) || (p == 8'h0E) ||
           (p == 8'h0F) || ((p >= 8'h10) && (p <= 8'h17));
  endfunction

  // Grouped stepping after each data byte
  function automatic logic [7:0] ptr_step(input logic [7:0] p);
    logic [7:0] n;
    if ((p < 8'h04) || (p == 8'h06) || (p == 8'h07) ||
        (p == 8'h0A) || (p == 8'h0B))
      n = p ^ 8'h01;
    else if (p == 8'h17)
      n = 8'h10;
    else if ((p >= 8'h10) && (p < 8'h17))
      n = p + 8'h01;
    else
      n = p;
    return n;
  endfunction

  function automatic logic ptr_writable(input logic [7:0] p);
    return ptr_known(p) && (p > 8'h01);
  endfunction

endpackage

// File: rtl/twi_glitch_filt.sv
module twi_glitch_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(HOLD + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (sync_q[SYNC_STAGES-1] == dout) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(HOLD - 1)) begin
        dout  <= sync_q[SYNC_STAGES-1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/twi_ptr_reg.sv
module twi_ptr_reg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  import twi_grp_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= ptr_step(ptr);
  end
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic [1:0]    sel,
  input  logic [7:0]    ptr,
  input  logic [7:0]    rd_data,
  output logic          sda_pull,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_stb,
  output logic          ptr_load,
  output logic [7:0]    ptr_val,
  output logic          ptr_adv
);
  import twi_grp_pkg::*;

  twi_state_e st_q;
  twi_phase_e ph_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic       rw_q, mack_q, scl_q, sda_q;
  logic       scl_rise, scl_fall, bus_start, bus_stop;
  logic [6:0] my_addr;
  logic [7:0] tx_byte;

  assign my_addr   = {sel[1], 1'b1, 2'b00, sel[0], 2'b00};
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
  assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
  assign tx_byte   = ptr_known(ptr) ? rd_data : 8'h00;

  always_ff @(posedge clk) begin
    wr_stb   <= 1'b0;
    rd_stb   <= 1'b0;
    ptr_load <= 1'b0;
    ptr_adv  <= 1'b0;
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ph_q     <= PH_ADDR;
      cnt_q    <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      sda_pull <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ptr_val  <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (bus_start) begin
        st_q     <= ST_RX;
        ph_q     <= PH_ADDR;
        cnt_q    <= '0;
        sda_pull <= 1'b0;
      end else if (bus_stop) begin
        st_q     <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st_q)
          ST_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              cnt_q <= '0;
              case (ph_q)
                PH_ADDR: begin
                  if (sh_q[7:1] == my_addr) begin
                    sda_pull <= 1'b1;
                    rw_q     <= sh_q[0];
                    st_q     <= ST_ACK;
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                PH_CMD: begin
                  ptr_load <= 1'b1;
                  ptr_val  <= sh_q;
                  ph_q     <= PH_DATA;
                  sda_pull <= 1'b1;
                  st_q     <= ST_ACK;
                end
                default: begin
                  wr_stb   <= ptr_writable(ptr);
                  wr_addr  <= ptr[AW-1:0];
                  wr_data  <= sh_q;
                  ptr_adv  <= 1'b1;
                  sda_pull <= 1'b1;
                  st_q     <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (ph_q == PH_ADDR) ph_q <= PH_CMD;
              if (rw_q) begin
                sh_q     <= tx_byte;
                sda_pull <= ~tx_byte[7];
                rd_stb   <= 1'b1;
                ptr_adv  <= 1'b1;
                cnt_q    <= '0;
                st_q     <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                st_q     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_pull <= 1'b0;
                st_q     <= ST_MACK;
              end else begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_pull <= ~sh_q[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (mack_q) begin
                sh_q     <= tx_byte;
                sda_pull <= ~tx_byte[7];
                rd_stb   <= 1'b1;
                ptr_adv  <= 1'b1;
                cnt_q    <= '0;
                st_q     <= ST_TX;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_grp_slave.sv
module twi_grp_slave #(
  parameter int REG_AW    = 5,
  parameter int FILT_SYNC = 2,
  parameter int FILT_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [1:0]        addr_sel,
  output logic [REG_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_stb,
  output logic [REG_AW-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              rd_stb
);
  localparam int NLINES = 2;
  localparam int PW     = 8;

  logic [NLINES-1:0] line_raw, line_flt;
  logic              ptr_load, ptr_adv;
  logic [PW-1:0]     ptr_val, ptr;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    twi_glitch_filt #(
      .SYNC_STAGES(FILT_SYNC),
      .HOLD       (FILT_HOLD)
    ) filt_i (
      .clk (clk),
      .rst_n(rst_n),
      .din (line_raw[g]),
      .dout(line_flt[g])
    );
  end

  twi_slave_fsm #(.AW(REG_AW)) fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (line_flt[0]),
    .sda_f   (line_flt[1]),
    .sel     (addr_sel),
    .ptr     (ptr),
    .rd_data (rd_data),
    .sda_pull(sda_pull_o),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_stb  (rd_stb),
    .ptr_load(ptr_load),
    .ptr_val (ptr_val),
    .ptr_adv (ptr_adv)
  );

  twi_ptr_reg #(.PW(PW)) ptr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ptr_load),
    .load_val(ptr_val),
    .adv     (ptr_adv),
    .ptr     (ptr)
  );

  assign rd_addr = ptr[REG_AW-1:0];
endmodule

// File: rtl/twi_grp_slave_chk.sv
module twi_grp_slave_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic [REG_AW-1:0] wr_addr,
  input logic              wr_stb,
  input logic              rd_stb
);
  AST_WSTB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R3

  AST_RO_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr > REG_AW'(1))); // R10

  AST_RSTB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R7

  AST_NO_MIXED_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb)); // R7

  AST_PULL_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(scl_i, 2)) |-> $stable(sda_pull_o)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!sda_pull_o && !wr_stb && !rd_stb)); // R9
endmodule

bind twi_grp_slave twi_grp_slave_chk #(.REG_AW(REG_AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_pull_o(sda_pull_o),
  .wr_addr   (wr_addr),
  .wr_stb    (wr_stb),
  .rd_stb    (rd_stb)
);

// File: tb/twi_grp_slave_tb_top.sv
module twi_grp_slave_tb_top;
  localparam int AW = 5;
  localparam int NREG = 1 << AW;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, glitch = 1'b0;
  logic [1:0] addr_sel = 2'b10;
  logic sda_pull_o, wr_stb, rd_stb;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_line, scl_line;

  logic [7:0] bregs [NREG];
  logic [7:0] mregs [NREG];
  logic [7:0] mptr;
  logic [7:0] dbuf [8];
  int checks = 0, failures = 0, cyc = 0, wcnt = 0, rcnt = 0, glitch_bit = -1;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull_o;
  assign scl_line = m_scl | glitch;
  assign rd_data  = bregs[rd_addr];

  twi_grp_slave #(.REG_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .addr_sel(addr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_stb(rd_stb)
  );

  always @(posedge clk) begin
    if (wr_stb) begin
      bregs[wr_addr] <= wr_data;
      wcnt <= wcnt + 1;
    end
    if (rd_stb) rcnt <= rcnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, all requirements, actual=%0d expected<%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  // ---------- requirement model ----------
  function automatic logic m_known(input logic [7:0] p);
    case (p)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h06, 8'h07, 8'h0A, 8'h0B,
      8'h0E, 8'h0F, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15,
      8'h16, 8'h17: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] m_next(input logic [7:0] p);
    if (!m_known(p) || p == 8'h0E || p == 8'h0F) return p;    // R5 R11
    if (p[4]) return {5'b00010, p[2:0] + 3'd1};               // R6
    return {p[7:1], ~p[0]};                                   // R4
  endfunction

  function automatic logic [6:0] dev_addr(input logic [1:0] s);
    return {s[1], 1'b1, 2'b00, s[0], 2'b00};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------- bus master ----------
  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b0; waitq(); m_scl = 1'b0; waitq();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq();
    m_sda = 1'b0; waitq(); m_scl = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq(); m_scl = 1'b1; waitq(); m_sda = 1'b1; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (i == glitch_bit) begin
        repeat (2) @(negedge clk);
        glitch = 1'b1; @(negedge clk); glitch = 1'b0;
        repeat (Q - 3) @(negedge clk);
      end else waitq();
      m_scl = 1'b1; waitq(); waitq();
      m_scl = 1'b0; waitq();
    end
    m_sda = 1'b1; waitq();
    m_scl = 1'b1; @(negedge clk); a1 = sda_line;
    repeat (2 * Q - 2) @(negedge clk); a2 = sda_line;
    @(negedge clk);
    m_scl = 1'b0; waitq();
    ack = !a1 && !a2;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; waitq();
      m_scl = 1'b1; waitq(); d[i] = sda_line; waitq();
      m_scl = 1'b0; waitq();
    end
    m_sda = !mack; waitq();
    m_scl = 1'b1; waitq(); waitq();
    m_scl = 1'b0; waitq();
    m_sda = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] cmd, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({dev_addr(addr_sel), 1'b0}, ack);
    chk(ack, "R1 address ack", ack, 1);
    send_byte(cmd, ack);
    chk(ack, "R8 pointer byte ack", ack, 1);
    mptr = cmd;
    for (int k = 0; k < n; k++) begin
      send_byte(dbuf[k], ack);
      chk(ack, {tag, " data ack"}, ack, 1);
      if (m_known(mptr) && mptr > 8'h01) mregs[mptr[AW-1:0]] = dbuf[k];
      mptr = m_next(mptr);
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic set_ptr, input logic [7:0] cmd, input int n,
                        input string tag);
    logic ack;
    logic [7:0] d, e;
    bus_start();
    if (set_ptr) begin
      send_byte({dev_addr(addr_sel), 1'b0}, ack);
      chk(ack, "R1 address ack", ack, 1);
      send_byte(cmd, ack);
      chk(ack, "R2 pointer byte ack", ack, 1);
      mptr = cmd;
      bus_rstart();
    end
    send_byte({dev_addr(addr_sel), 1'b1}, ack);
    chk(ack, "R12 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      e = m_known(mptr) ? mregs[mptr[AW-1:0]] : 8'h00;
      chk(d == e, {tag, " read data"}, d, e);
      mptr = m_next(mptr);
    end
    bus_stop();
  endtask

  function automatic logic [7:0] pick_ptr(input int i);
    if (i < 4)  return 8'(i);
    if (i < 6)  return 8'(i + 2);
    if (i < 8)  return 8'(i + 4);
    if (i < 10) return 8'(i + 6);
    if (i < 18) return 8'(i + 6);
    if (i == 18) return 8'h05;
    return 8'h1C;
  endfunction

  initial begin
    logic ack;
    int w0, r0;
    void'($urandom(32'd4177));
    for (int i = 0; i < NREG; i++) begin
      bregs[i] = 8'(i * 37 + 5);
      mregs[i] = 8'(i * 37 + 5);
    end
    mptr = 8'h00;
    repeat (6) @(negedge clk);
    chk(sda_pull_o == 1'b0 && wr_stb == 1'b0 && rd_stb == 1'b0,
        "R9 reset state", {sda_pull_o, wr_stb, rd_stb}, 0);
    rst_n = 1'b1;
    waitq();

    // R1: four select codes, and a foreign address
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      bus_start();
      send_byte({dev_addr(2'(s)), 1'b0}, ack);
      chk(ack, "R1 own address acknowledged", ack, 1);
      bus_stop();
      bus_start();
      send_byte({dev_addr(2'(s ^ 1)), 1'b0}, ack);
      chk(!ack, "R1 foreign address not acknowledged", ack, 0);
      bus_stop();
    end
    addr_sel = 2'b10;

    // R2: pointer only, then read from stored pointer
    bus_start();
    send_byte({dev_addr(addr_sel), 1'b0}, ack);
    send_byte(8'h13, ack);
    chk(ack, "R2 pointer byte ack", ack, 1);
    bus_stop();
    mptr = 8'h13;
    rd_txn(1'b0, 8'h00, 1, "R2");

    // R3 R4: pair swapping on writes
    w0 = wcnt;
    dbuf[0] = 8'hA1; dbuf[1] = 8'hB2; dbuf[2] = 8'hC3;
    wr_txn(8'h02, 3, "R4");
    chk(wcnt - w0 == 3, "R3 write strobe count", wcnt - w0, 3);
    rd_txn(1'b1, 8'h02, 2, "R4");
    dbuf[0] = 8'h5A; dbuf[1] = 8'h6B;
    wr_txn(8'h0B, 2, "R4");
    rd_txn(1'b1, 8'h0A, 3, "R4");

    // R5: fixed pointer
    dbuf[0] = 8'h11; dbuf[1] = 8'h22;
    wr_txn(8'h0E, 2, "R5");
    rd_txn(1'b1, 8'h0E, 2, "R5");
    chk(bregs[5'h0E] == 8'h22, "R5 second byte overwrote", bregs[5'h0E], 8'h22);

    // R6: wrap 0x17 -> 0x10
    dbuf[0] = 8'h77; dbuf[1] = 8'h70;
    wr_txn(8'h17, 2, "R6");
    chk(bregs[5'h10] == 8'h70, "R6 wrap write", bregs[5'h10], 8'h70);
    rd_txn(1'b1, 8'h16, 3, "R6");

    // R7: strobe per byte and NACK end
    r0 = rcnt;
    rd_txn(1'b1, 8'h10, 3, "R7");
    chk(rcnt - r0 == 3, "R7 read strobe count", rcnt - r0, 3);
    chk(sda_pull_o == 1'b0, "R7 line released after NACK", sda_pull_o, 0);

    // R10: read-only pair ignored, pointer still swaps
    w0 = wcnt;
    dbuf[0] = 8'hEE; dbuf[1] = 8'hDD; dbuf[2] = 8'hCC;
    wr_txn(8'h00, 3, "R10");
    chk(wcnt == w0, "R10 no write strobe", wcnt - w0, 0);
    chk(bregs[0] == 8'h05 && bregs[1] == 8'h2A, "R10 contents kept", bregs[0], 8'h05);
    rd_txn(1'b0, 8'h00, 1, "R10");

    // R11: unused pointer
    w0 = wcnt;
    dbuf[0] = 8'h99;
    wr_txn(8'h05, 1, "R11");
    chk(wcnt == w0, "R11 no write strobe", wcnt - w0, 0);
    rd_txn(1'b0, 8'h00, 2, "R11");
    rd_txn(1'b1, 8'h1C, 1, "R11");

    // R12: write then repeated START keeps pointer
    bus_start();
    send_byte({dev_addr(addr_sel), 1'b0}, ack);
    send_byte(8'h11, ack);
    send_byte(8'h3C, ack);
    mregs[5'h11] = 8'h3C;
    mptr = 8'h12;
    bus_rstart();
    send_byte({dev_addr(addr_sel), 1'b1}, ack);
    chk(ack, "R12 read after repeated start ack", ack, 1);
    begin
      logic [7:0] d;
      recv_byte(1'b0, d);
      chk(d == mregs[5'h12], "R12 pointer kept", d, mregs[5'h12]);
    end
    bus_stop();
    mptr = 8'h13;

    // R13: one-cycle SCL spikes inside every bit
    glitch_bit = 9;
    dbuf[0] = 8'h3E; dbuf[1] = 8'hC1;
    for (int b = 0; b < 8; b++) begin
      glitch_bit = b;
      dbuf[0] = 8'(8'h3E + b);
      wr_txn(8'h06, 1, "R13");
    end
    glitch_bit = -1;
    rd_txn(1'b1, 8'h06, 1, "R13");

    // R9: reset in the middle of a data byte
    w0 = wcnt;
    bus_start();
    send_byte({dev_addr(addr_sel), 1'b0}, ack);
    send_byte(8'h14, ack);
    for (int i = 0; i < 4; i++) begin
      m_sda = 1'b0; waitq(); m_scl = 1'b1; waitq(); waitq(); m_scl = 1'b0; waitq();
    end
    m_scl = 1'b1; waitq();
    rst_n = 1'b0;
    m_sda = 1'b1;
    repeat (3) @(negedge clk);
    chk(sda_pull_o == 1'b0, "R9 line released in reset", sda_pull_o, 0);
    rst_n = 1'b1;
    waitq(); waitq();
    chk(wcnt == w0, "R9 no write from aborted byte", wcnt - w0, 0);
    mptr = 8'h00;
    rd_txn(1'b0, 8'h00, 1, "R9");

    // random mix over all groups
    for (int t = 0; t < 30; t++) begin
      logic [7:0] p;
      int n;
      p = pick_ptr($urandom_range(0, 19));
      n = $urandom_range(1, 3);
      if ($urandom_range(0, 1) == 0) begin
        for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom_range(0, 255));
        wr_txn(p, n, "R3");
      end else if ($urandom_range(0, 2) == 0) begin
        rd_txn(1'b0, 8'h00, n, "R7");
      end else begin
        rd_txn(1'b1, p, n, "R7");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule